// File: doc/BRIEF.md
# Packet Pool with Beat-Serialized Transfers

The block is a first-in first-out store of fixed-size records sitting between the shader compute units and the traversal engine. Each record moves over a 128-bit datapath as a short train of beats. A ray record is three beats. An intersection record is six beats, with the last beat only partly used. One producer owns the write port and one consumer owns the read port. Either port takes a request only when it is idle. Every request costs a fixed setup overhead, and the cycle of the handshake counts as the first overhead cycle. After that, one beat moves per cycle. As a result, back-to-back requests on one port take exactly overhead plus beats cycles each.

Records are screened as they arrive. The first beat carries a small header. A record whose bounce depth is above the configured limit is not stored, and neither is a record marked null. Its write request still runs its full beat train, so the producer never waits on a discarded record. The pool reports three counts to the host controller: the number of stored records, the number of stored records marked as shadow, and the number not so marked.

Top module: `pkt_pool`

## Requirements
- R1: While reset is held, wr_ready is 1, rd_ready, rd_valid and rd_last are 0, and all three counts are 0.
- R2: A write request is taken on a cycle with wr_req and wr_ready both high. wr_ready is high only when the write port is idle and fewer than DEPTH (default 512) records are stored.
- R3: After a taken write request, OVH-1 cycles pass (OVH defaults to 2). Then wr_beat_en is high for exactly BEATS consecutive cycles (default 3), and wr_data is sampled at the end of each of those cycles, beat 0 first.
- R4: After a taken read request, OVH-1 cycles pass. Then rd_valid is high for exactly BEATS consecutive cycles, and rd_last is high together with rd_valid on the final one only.
- R5: Stored records are read back in the order they were written, with every beat bit-exact.
- R6: Header bits [3:0] of beat 0 hold the bounce depth. A record whose depth is greater than HOP_LIMIT (default 5) is discarded, and a record whose depth equals HOP_LIMIT is stored.
- R7: Header bit 4 of beat 0 is the null flag. A record with the flag set is discarded whatever its depth.
- R8: A discarded record's write request keeps the full R3 timing, including all of its wr_beat_en cycles.
- R9: pkg_count equals the number of stored records. It rises in the cycle after the last beat of a stored record is written, and falls in the cycle after rd_last.
- R10: Header bit 5 of beat 0 is the shadow flag. shadow_count counts stored records with the flag set, normal_count counts those with it clear, and the two always add up to pkg_count.
- R11: rd_ready is high only when the read port is idle and pkg_count is non-zero.
- R12: While DEPTH records are stored, wr_ready stays low and nothing is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Producer asks to start a write |
| wr_ready | output | 1 | Write port idle and pool not full |
| wr_beat_en | output | 1 | wr_data is taken at the end of this cycle |
| wr_data | input | BEAT_W | Write beat |
| rd_req | input | 1 | Consumer asks to start a read |
| rd_ready | output | 1 | Read port idle and pool not empty |
| rd_valid | output | 1 | rd_data holds a beat |
| rd_last | output | 1 | Final beat of the record |
| rd_data | output | BEAT_W | Read beat |
| pkg_count | output | CNT_W | Stored record count |
| shadow_count | output | CNT_W | Stored records with the shadow flag set |
| normal_count | output | CNT_W | Stored records with the shadow flag clear |

## Verification
The hardest state to reach is a completely full pool while the write port keeps asking, followed by a drain. Reaching it takes 512 accepted records in a row, and any record that happened to be discarded on the way does not count. The stimulus therefore switches to a mode that generates only storable headers and holds wr_req high until the reference queue reports full. It then keeps asking for a while, so that a lost or overwritten record would show up during the full drain that follows. The header boundaries (depth equal to the limit, one above it, the largest depth value, null with depth zero) are driven one record at a time from an idle pool, so that each count step can be attributed to a single record.

// File: rtl/pkt_pool_pkg.sv
package pkt_pool_pkg;
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SETUP = 2'd1,
    XS_BEAT  = 2'd2
  } xfer_st_e;

  // header fields carried in the low bits of beat 0
  localparam int HOP_LSB    = 0;
  localparam int HOP_W      = 4;
  localparam int NULL_POS   = 4;
  localparam int SHADOW_POS = 5;
  localparam int HDR_W      = 6;
endpackage

// File: rtl/pool_xfer_seq.sv
module pool_xfer_seq
  import pkt_pool_pkg::*;
#(
  parameter int OVH   = 2,
  parameter int BEATS = 3,
  localparam int BIDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              idle,
  output logic              beat_act,
  output logic              beat_last,
  output logic [BIDX_W-1:0] beat_idx
);
  localparam int WAIT_W = (OVH > 2) ? $clog2(OVH) : 1;

  xfer_st_e           st_q, st_d;
  logic [WAIT_W-1:0]  wait_q, wait_d;
  logic [BIDX_W-1:0]  idx_q, idx_d;
  logic               adv;

  assign idle      = (st_q == XS_IDLE);
  assign beat_act  = (st_q == XS_BEAT);
  assign beat_last = beat_act && (idx_q == BIDX_W'(BEATS - 1));
  assign beat_idx  = idx_q;
  assign adv       = !idle || start;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    idx_d  = idx_q;
    case (st_q)
      XS_IDLE: begin
        if (start) begin
          wait_d = '0;
          idx_d  = '0;
          st_d   = (OVH > 1) ? XS_SETUP : XS_BEAT;
        end
      end
      XS_SETUP: begin
        if (wait_q == WAIT_W'(OVH - 2)) st_d = XS_BEAT;
        else                            wait_d = wait_q + 1'b1;
      end
      XS_BEAT: begin
        if (beat_last) begin
          st_d  = XS_IDLE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      wait_q <= '0;
      idx_q  <= '0;
    end else if (adv) begin
      st_q   <= st_d;
      wait_q <= wait_d;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/pool_entry_filter.sv
module pool_entry_filter
  import pkt_pool_pkg::*;
#(
  parameter int HOP_LIMIT = 5
) (
  input  logic [HDR_W-1:0] hdr,
  output logic             keep,
  output logic             shadow
);
  logic [HOP_W-1:0] hops;

  assign hops   = hdr[HOP_LSB +: HOP_W];
  assign keep   = !hdr[NULL_POS] && (hops <= HOP_W'(HOP_LIMIT));
  assign shadow = hdr[SHADOW_POS];
endmodule

// File: rtl/pool_occupancy.sv
module pool_occupancy #(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_shadow,
  input  logic             pop,
  input  logic             pop_shadow,
  output logic [CNT_W-1:0] pkg_count,
  output logic [CNT_W-1:0] shadow_count,
  output logic [CNT_W-1:0] normal_count
);
  logic [CNT_W-1:0] pkg_q, pkg_d, sh_q, sh_d, nm_q, nm_d;
  logic             upd;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return cur + 1'b1;
      2'b01:   return cur - 1'b1;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    pkg_d = step(pkg_q, push, pop);
    sh_d  = step(sh_q, push && push_shadow, pop && pop_shadow);
    nm_d  = step(nm_q, push && !push_shadow, pop && !pop_shadow);
  end

  assign upd = push || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkg_q <= '0;
      sh_q  <= '0;
      nm_q  <= '0;
    end else if (upd) begin
      pkg_q <= pkg_d;
      sh_q  <= sh_d;
      nm_q  <= nm_d;
    end
  end

  assign pkg_count    = pkg_q;
  assign shadow_count = sh_q;
  assign normal_count = nm_q;
endmodule

// File: rtl/pkt_pool.sv
module pkt_pool
  import pkt_pool_pkg::*;
#(
  parameter int BEAT_W    = 128,
  parameter int DEPTH     = 512,
  parameter int BEATS     = 3,
  parameter int OVH       = 2,
  parameter int HOP_LIMIT = 5,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  output logic              wr_ready,
  output logic              wr_beat_en,
  input  logic [BEAT_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic              rd_last,
  output logic [BEAT_W-1:0] rd_data,
  output logic [CNT_W-1:0]  pkg_count,
  output logic [CNT_W-1:0]  shadow_count,
  output logic [CNT_W-1:0]  normal_count
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WORDS  = DEPTH * BEATS;
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BIDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BEAT_W-1:0] store [WORDS];

  logic              wr_idle, wr_act, wr_lst, wr_accept;
  logic [BIDX_W-1:0] wr_idx;
  logic              rd_idle, rd_act, rd_lst, rd_accept;
  logic [BIDX_W-1:0] rd_idx;

  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [ADDR_W-1:0] wr_addr, rd_addr, head_addr;
  logic              f_keep, f_shadow, keep_q, shadow_q;
  logic              keep_now, shadow_now, first_beat;
  logic              push, pop;
  logic [BEAT_W-1:0] head_word;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // port handshakes
  assign wr_ready  = wr_idle && (pkg_count != CNT_W'(DEPTH));
  assign wr_accept = wr_req && wr_ready;
  assign rd_ready  = rd_idle && (pkg_count != '0);
  assign rd_accept = rd_req && rd_ready;

  pool_xfer_seq #(.OVH(OVH), .BEATS(BEATS)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_accept),
    .idle(wr_idle), .beat_act(wr_act), .beat_last(wr_lst), .beat_idx(wr_idx)
  );

  pool_xfer_seq #(.OVH(OVH), .BEATS(BEATS)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .start(rd_accept),
    .idle(rd_idle), .beat_act(rd_act), .beat_last(rd_lst), .beat_idx(rd_idx)
  );

  // entry screening on beat 0, held for the rest of the train
  pool_entry_filter #(.HOP_LIMIT(HOP_LIMIT)) u_filter (
    .hdr(wr_data[HDR_W-1:0]), .keep(f_keep), .shadow(f_shadow)
  );

  assign first_beat = wr_act && (wr_idx == '0);
  assign keep_now   = first_beat ? f_keep   : keep_q;
  assign shadow_now = first_beat ? f_shadow : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q   <= 1'b0;
      shadow_q <= 1'b0;
    end else if (first_beat) begin
      keep_q   <= f_keep;
      shadow_q <= f_shadow;
    end
  end

  // beat addressing: record slot times BEATS plus beat index
  assign wr_addr   = ADDR_W'(wptr_q) * ADDR_W'(BEATS) + ADDR_W'(wr_idx);
  assign rd_addr   = ADDR_W'(rptr_q) * ADDR_W'(BEATS) + ADDR_W'(rd_idx);
  assign head_addr = ADDR_W'(rptr_q) * ADDR_W'(BEATS);

  always_ff @(posedge clk) begin
    if (wr_act && keep_now) store[wr_addr] <= wr_data;
  end

  assign head_word = store[head_addr];
  assign rd_data   = store[rd_addr];
  assign rd_valid  = rd_act;
  assign rd_last   = rd_lst;
  assign wr_beat_en = wr_act;

  assign push = wr_lst && keep_now;
  assign pop  = rd_lst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= wrap_inc(wptr_q);
      if (pop)  rptr_q <= wrap_inc(rptr_q);
    end
  end

  pool_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_shadow(shadow_now),
    .pop(pop), .pop_shadow(head_word[SHADOW_POS]),
    .pkg_count(pkg_count), .shadow_count(shadow_count),
    .normal_count(normal_count)
  );
endmodule

// File: rtl/pkt_pool_chk.sv
module pkt_pool_chk #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_req,
  input logic             wr_ready,
  input logic             wr_beat_en,
  input logic             rd_ready,
  input logic             rd_valid,
  input logic             rd_last,
  input logic [CNT_W-1:0] pkg_count,
  input logic [CNT_W-1:0] shadow_count,
  input logic [CNT_W-1:0] normal_count
);
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_count <= CNT_W'(DEPTH));

  a_r12_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_count == CNT_W'(DEPTH)) |-> !wr_ready);

  a_r11_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_count == '0) |-> !rd_ready);

  a_r4_last_inside_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  a_r4_valid_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_ready);

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ready) |=> !wr_ready);

  a_r3_beat_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat_en |-> !wr_ready);

  a_r10_counts_split: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, shadow_count} + {1'b0, normal_count}) == {1'b0, pkg_count});

  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pkg_count} <= {1'b0, $past(pkg_count)} + 1'b1) &&
    ({1'b0, pkg_count} + 1'b1 >= {1'b0, $past(pkg_count)}));
endmodule

bind pkt_pool pkt_pool_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ready(wr_ready),
  .wr_beat_en(wr_beat_en), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .rd_last(rd_last), .pkg_count(pkg_count), .shadow_count(shadow_count),
  .normal_count(normal_count)
);

// File: tb/pkt_pool_tb.sv
`timescale 1ns/1ps
module pkt_pool_tb;
  localparam int BW    = 128;
  localparam int DEPTH = 512;
  localparam int BEATS = 3;
  localparam int OVH   = 2;
  localparam int LIMIT = 5;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PW    = BEATS * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [BW-1:0] wr_data = '0;
  logic wr_ready, wr_beat_en, rd_ready, rd_valid, rd_last;
  logic [BW-1:0] rd_data;
  logic [CNT_W-1:0] pkg_count, shadow_count, normal_count;

  always #2 clk = ~clk;

  pkt_pool #(.BEAT_W(BW), .DEPTH(DEPTH), .BEATS(BEATS), .OVH(OVH),
             .HOP_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ready(wr_ready),
    .wr_beat_en(wr_beat_en), .wr_data(wr_data), .rd_req(rd_req),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_last(rd_last),
    .rd_data(rd_data), .pkg_count(pkg_count), .shadow_count(shadow_count),
    .normal_count(normal_count)
  );

  // reference model state
  logic [PW-1:0] q[$];
  logic [PW-1:0] cur_pkg = '0;
  logic [PW-1:0] pend_pkg = '0;
  int wr_ph = -1;
  int rd_ph = -1;
  int wr_pct = 0, rd_pct = 0;
  bit force_good = 0;
  bit done = 0;
  int compared = 0, mismatched = 0, cyc = 0;

  function automatic logic [PW-1:0] make_pkg(bit good);
    logic [PW-1:0] p;
    for (int i = 0; i < PW / 32; i++) p[i*32 +: 32] = $urandom();
    if (good) begin
      p[3:0] = 4'($urandom_range(0, LIMIT));
      p[4]   = 1'b0;
    end else begin
      p[3:0] = 4'($urandom_range(0, 7));
      p[4]   = ($urandom_range(0, 5) == 0);
    end
    return p;
  endfunction

  function automatic bit kept(logic [PW-1:0] p);
    return !p[4] && (int'(p[3:0]) <= LIMIT);
  endfunction

  function automatic int count_shadow();
    int n = 0;
    foreach (q[i]) if (q[i][5]) n++;
    return n;
  endfunction

  task automatic chk(string tag, logic [BW-1:0] got, logic [BW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // model advances on each rising edge
  always @(posedge clk) begin
    int n0;
    cyc++;
    if (!rst_n) begin
      q.delete();
      wr_ph = -1;
      rd_ph = -1;
      pend_pkg = make_pkg(force_good);
    end else begin
      n0 = q.size();
      if (rd_ph >= 0) begin
        if (rd_ph == OVH + BEATS - 1) begin
          void'(q.pop_front());
          rd_ph = -1;
        end else rd_ph++;
      end else if (rd_req && n0 > 0) rd_ph = 1;

      if (wr_ph >= 0) begin
        if (wr_ph == OVH + BEATS - 1) begin
          if (kept(cur_pkg)) q.push_back(cur_pkg);
          wr_ph = -1;
        end else wr_ph++;
      end else if (wr_req && n0 < DEPTH) begin
        cur_pkg  = pend_pkg;
        pend_pkg = make_pkg(force_good);
        wr_ph    = 1;
      end
    end
    if (cyc > 150000 && !done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  // compare every cycle on the falling edge, then drive the next inputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int sh;
      sh = count_shadow();
      chk("R2 wr_ready", BW'(wr_ready), BW'((wr_ph < 0) && (q.size() < DEPTH)));
      chk("R11 rd_ready", BW'(rd_ready), BW'((rd_ph < 0) && (q.size() > 0)));
      if (wr_ph >= OVH && !kept(cur_pkg))
        chk("R8 wr_beat_en on discarded record", BW'(wr_beat_en), BW'(1));
      else
        chk("R3 wr_beat_en", BW'(wr_beat_en), BW'(wr_ph >= OVH));
      chk("R4 rd_valid", BW'(rd_valid), BW'(rd_ph >= OVH));
      chk("R4 rd_last", BW'(rd_last), BW'(rd_ph == OVH + BEATS - 1));
      if (rd_ph >= OVH)
        chk("R5 rd_data", rd_data, q[0][(rd_ph - OVH) * BW +: BW]);
      chk("R9 pkg_count", BW'(pkg_count), BW'(q.size()));
      chk("R10 shadow_count", BW'(shadow_count), BW'(sh));
      chk("R10 normal_count", BW'(normal_count), BW'(q.size() - sh));
    end
    if (!rst_n) begin
      wr_req <= 1'b0;
      rd_req <= 1'b0;
    end else begin
      wr_req <= ($urandom_range(0, 99) < wr_pct);
      rd_req <= ($urandom_range(0, 99) < rd_pct);
    end
    if (wr_ph >= OVH) wr_data <= cur_pkg[(wr_ph - OVH) * BW +: BW];
    else              wr_data <= {4{$urandom()}};
  end

  task automatic send_one(logic [5:0] hdr, int d_tot, int d_sh, string tag);
    int before_tot, before_sh;
    @(posedge clk); #1;
    before_tot = int'(pkg_count);
    before_sh  = int'(shadow_count);
    pend_pkg[5:0] = hdr;
    wr_pct = 100;
    while (wr_ph < 0) begin @(posedge clk); #1; end
    wr_pct = 0;
    repeat (OVH + BEATS + 2) @(posedge clk);
    #1;
    chk({tag, " pkg_count step"}, BW'(pkg_count), BW'(before_tot + d_tot));
    chk({tag, " shadow_count step"}, BW'(shadow_count), BW'(before_sh + d_sh));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 wr_ready in reset", BW'(wr_ready), BW'(1));
    chk("R1 rd_ready in reset", BW'(rd_ready), BW'(0));
    chk("R1 rd_valid in reset", BW'(rd_valid), BW'(0));
    chk("R1 rd_last in reset", BW'(rd_last), BW'(0));
    chk("R1 counts in reset", BW'({pkg_count, shadow_count, normal_count}), BW'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;

    // mixed traffic, write-heavy then read-heavy
    wr_pct = 70; rd_pct = 40;
    repeat (3000) @(posedge clk);
    wr_pct = 40; rd_pct = 80;
    repeat (2000) @(posedge clk);

    // R12: fill to capacity and keep pushing
    #1;
    wr_pct = 0; rd_pct = 0;
    force_good = 1;
    repeat (10) @(posedge clk);
    #1;
    wr_pct = 100;
    for (int i = 0; i < 6000 && q.size() < DEPTH; i++) begin @(posedge clk); #1; end
    repeat (30) @(posedge clk);
    #1;
    chk("R12 wr_ready while full", BW'(wr_ready), BW'(0));
    chk("R12 pkg_count at capacity", BW'(pkg_count), BW'(DEPTH));
    wr_pct = 0;
    force_good = 0;

    // drain completely, order and data checked each beat
    rd_pct = 100;
    for (int i = 0; i < 6000 && (q.size() > 0 || rd_ph >= 0); i++) begin
      @(posedge clk); #1;
    end
    rd_pct = 0;
    repeat (5) @(posedge clk);
    #1;
    chk("R11 rd_ready when empty", BW'(rd_ready), BW'(0));

    // header boundaries: {shadow, null, depth[3:0]}
    send_one({1'b0, 1'b0, 4'(LIMIT)},     1, 0, "R6 depth at limit kept");
    send_one({1'b0, 1'b0, 4'(LIMIT + 1)}, 0, 0, "R6 depth above limit dropped");
    send_one({1'b1, 1'b0, 4'hF},          0, 0, "R6 largest depth dropped");
    send_one({1'b0, 1'b1, 4'h0},          0, 0, "R7 null record dropped");
    send_one({1'b1, 1'b1, 4'(LIMIT)},     0, 0, "R7 null shadow dropped");
    send_one({1'b1, 1'b0, 4'h0},          1, 1, "R10 shadow record counted");

    // final random burst
    wr_pct = 60; rd_pct = 60;
    repeat (1500) @(posedge clk);
    #1;
    wr_pct = 0; rd_pct = 0;
    repeat (20) @(posedge clk);
    #1;
    done = 1;
    summary();
    $finish;
  end
endmodule